// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test-port front end of a memory device. It follows the sixteen-state test state machine clocked by `tck` and steered by `tms`. It holds a three-bit instruction register, a one-bit bypass stage and a 32-bit fixed identification register. A falling-edge output stage picks which register's least significant bit appears on `tdo`. The boundary-scan cells sit outside this block. They take `tdi` directly, return their serial output on `bsr_so`, and follow the capture, shift and update strobes that this block raises while a boundary-scan instruction is active.

The instruction decode also produces two pin-control flags for the device's output drivers. One selects externally driven test data. The other forces every data output to high impedance and holds it there until a different instruction is applied. Reserved instruction codes route the scan chain through the bypass stage.

There is no dedicated test-reset pin. The controller reaches Test-Logic-Reset through the power-on reset `rst_n`, or through five consecutive rising `tck` edges with `tms` high. Every pin is a plain level or strobe, so no valid/ready back-pressure applies. Serial data moves one bit per `tck` rising edge while the controller sits in a shift state.

Top module: `tap_ctrl`

## Requirements
- R1: From any state, five consecutive `tck` rising edges with `tms` high bring the controller to Test-Logic-Reset. Four such edges from Shift-DR do not reach it.
- R2: The active instruction is IDCODE (code 001) after `rst_n`, and again on the first rising edge after the controller has been in Test-Logic-Reset.
- R3: Capture-IR loads the instruction shift stage with binary 001 (the two low bits are 01 and the top bit is 0). Shift-IR shifts it out least significant bit first, with `tdi` entering at the most significant bit.
- R4: A shifted instruction becomes active only on the Update-IR edge. While it is being shifted or paused, the decoded outputs keep the previous instruction's values.
- R5: Under IDCODE (001), Capture-DR loads the 32-bit constant `ID_VALUE`. Shift-DR presents it on `tdo` least significant bit first, and after 32 shifts the `tdi` bits follow.
- R6: Under BYPASS (111) and under the reserved codes 011, 101 and 110, Capture-DR clears the one-bit bypass stage to 0. In Shift-DR, `tdo` shows that 0 first and then `tdi` delayed by one shift.
- R7: The codes EXTEST (000), SAMPLE Z (010) and SAMPLE/PRELOAD (100) raise `sel_bsr` and route `bsr_so` to `tdo` during Shift-DR. All other codes keep `sel_bsr` low.
- R8: `extest_on` is high only while 000 is active. `outputs_hiz` is high only while 010 is active, so it persists until the next Update-IR or Test-Logic-Reset.
- R9: `cap_dr`, `shift_dr` and `upd_dr` are high in Capture-DR, Shift-DR and Update-DR respectively, and only while `sel_bsr` is high.
- R10: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is 1 only in Shift-IR and Shift-DR, and `tdo` is 0 whenever `tdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the external boundary-scan chain |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| sel_bsr | output | 1 | Boundary-scan register is the selected data register |
| extest_on | output | 1 | Boundary cells drive the device pins |
| outputs_hiz | output | 1 | Force all data outputs to high impedance |
| cap_dr | output | 1 | Boundary-scan capture strobe |
| shift_dr | output | 1 | Boundary-scan shift strobe |
| upd_dr | output | 1 | Boundary-scan update strobe |

## Verification
The hardest situation to reach from the ports is a high-impedance hold that must survive a new instruction being shifted in but not yet applied. The stimulus loads SAMPLE Z and then shifts a different code. It parks the controller in Pause-IR, where the flags must still show the old instruction, and only then completes the update. The same holding state is then exercised with four `tms`-high edges, which must leave the instruction in place, followed by a fifth, which must reset it. All eight codes are swept one after another, so each decode is checked against the code that preceded it.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_TLR   = 4'h0,
    ST_RTI   = 4'h1,
    ST_SELDR = 4'h2,
    ST_CAPDR = 4'h3,
    ST_SHDR  = 4'h4,
    ST_EX1DR = 4'h5,
    ST_PSDR  = 4'h6,
    ST_EX2DR = 4'h7,
    ST_UPDR  = 4'h8,
    ST_SELIR = 4'h9,
    ST_CAPIR = 4'hA,
    ST_SHIR  = 4'hB,
    ST_EX1IR = 4'hC,
    ST_PSIR  = 4'hD,
    ST_EX2IR = 4'hE,
    ST_UPIR  = 4'hF
  } tap_state_e;

  typedef enum logic [1:0] {
    DR_BSR = 2'd0,
    DR_ID  = 2'd1,
    DR_BYP = 2'd2
  } dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ   = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e st
);

  tap_state_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_TLR:   nxt = tms ? ST_TLR   : ST_RTI;
      ST_RTI:   nxt = tms ? ST_SELDR : ST_RTI;
      ST_SELDR: nxt = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: nxt = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  nxt = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: nxt = tms ? ST_UPDR  : ST_PSDR;
      ST_PSDR:  nxt = tms ? ST_EX2DR : ST_PSDR;
      ST_EX2DR: nxt = tms ? ST_UPDR  : ST_SHDR;
      ST_UPDR:  nxt = tms ? ST_SELDR : ST_RTI;
      ST_SELIR: nxt = tms ? ST_TLR   : ST_CAPIR;
      ST_CAPIR: nxt = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  nxt = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: nxt = tms ? ST_UPIR  : ST_PSIR;
      ST_PSIR:  nxt = tms ? ST_EX2IR : ST_PSIR;
      ST_EX2IR: nxt = tms ? ST_UPIR  : ST_SHIR;
      ST_UPIR:  nxt = tms ? ST_SELDR : ST_RTI;
      default:  nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st <= ST_TLR;
    else        st <= nxt;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      st,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_act,
  output logic            ir_lsb,
  output dr_sel_e         dr_sel,
  output logic            extest_on,
  output logic            outputs_hiz
);

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sh  <= OP_IDCODE;
      ir_act <= OP_IDCODE;
    end else begin
      unique case (st)
        ST_TLR:   ir_act <= OP_IDCODE;
        ST_CAPIR: ir_sh  <= IR_CAPTURE;
        ST_SHIR:  ir_sh  <= {tdi, ir_sh[IR_W-1:1]};
        ST_UPIR:  ir_act <= ir_sh;
        default:  ;
      endcase
    end
  end

  assign ir_lsb = ir_sh[0];

  always_comb begin
    extest_on   = 1'b0;
    outputs_hiz = 1'b0;
    unique case (ir_act)
      OP_EXTEST: begin dr_sel = DR_BSR; extest_on = 1'b1; end
      OP_IDCODE: dr_sel = DR_ID;
      OP_SAMPZ:  begin dr_sel = DR_BSR; outputs_hiz = 1'b1; end
      OP_SAMPLE: dr_sel = DR_BSR;
      default:   dr_sel = DR_BYP;
    endcase
  end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_3069
)(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e st,
  input  logic       tdi,
  input  dr_sel_e    dr_sel,
  output logic       id_lsb,
  output logic       byp
);

  logic [ID_W-1:0] id_sh;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      id_sh <= ID_VALUE;
      byp   <= 1'b0;
    end else if (st == ST_CAPDR) begin
      if (dr_sel == DR_ID)  id_sh <= ID_VALUE;
      if (dr_sel == DR_BYP) byp   <= 1'b0;
    end else if (st == ST_SHDR) begin
      if (dr_sel == DR_ID)  id_sh <= {tdi, id_sh[ID_W-1:1]};
      if (dr_sel == DR_BYP) byp   <= tdi;
    end
  end

  assign id_lsb = id_sh[0];

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_3069
)(
  input  logic tck,
  input  logic rst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_oe,
  output logic sel_bsr,
  output logic extest_on,
  output logic outputs_hiz,
  output logic cap_dr,
  output logic shift_dr,
  output logic upd_dr
);

  tap_state_e      st;
  logic [IR_W-1:0] ir_act;
  logic            ir_lsb;
  dr_sel_e         dr_sel;
  logic            id_lsb;
  logic            byp;
  logic            dr_bit;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .st    (st)
  );

  tap_ir u_ir (
    .tck         (tck),
    .rst_n       (rst_n),
    .st          (st),
    .tdi         (tdi),
    .ir_act      (ir_act),
    .ir_lsb      (ir_lsb),
    .dr_sel      (dr_sel),
    .extest_on   (extest_on),
    .outputs_hiz (outputs_hiz)
  );

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck    (tck),
    .rst_n  (rst_n),
    .st     (st),
    .tdi    (tdi),
    .dr_sel (dr_sel),
    .id_lsb (id_lsb),
    .byp    (byp)
  );

  assign sel_bsr  = (dr_sel == DR_BSR);
  assign cap_dr   = sel_bsr && (st == ST_CAPDR);
  assign shift_dr = sel_bsr && (st == ST_SHDR);
  assign upd_dr   = sel_bsr && (st == ST_UPDR);

  always_comb begin
    unique case (dr_sel)
      DR_BSR:  dr_bit = bsr_so;
      DR_ID:   dr_bit = id_lsb;
      default: dr_bit = byp;
    endcase
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else if (st == ST_SHIR) begin
      tdo    <= ir_lsb;
      tdo_oe <= 1'b1;
    end else if (st == ST_SHDR) begin
      tdo    <= dr_bit;
      tdo_oe <= 1'b1;
    end else begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end
  end

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
  import tap_pkg::*;
(
  input logic            tck,
  input logic            rst_n,
  input logic            tms,
  input tap_state_e      st,
  input logic [IR_W-1:0] ir_act,
  input logic            tdo,
  input logic            tdo_oe,
  input logic            sel_bsr,
  input logic            cap_dr,
  input logic            shift_dr,
  input logic            upd_dr,
  input logic            outputs_hiz
);

  logic [2:0] ones;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       ones <= 3'd0;
    else if (!tms)    ones <= 3'd0;
    else if (ones < 3'd5) ones <= ones + 3'd1;
  end

  assert_tms_reset_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (tms && ones >= 3'd4) |=> (st == ST_TLR));

  assert_tlr_idcode_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (st == ST_TLR) |=> (ir_act == OP_IDCODE));

  assert_ir_update_only_R4: assert property (@(posedge tck) disable iff (!rst_n)
    !(st == ST_UPIR || st == ST_TLR) |=> $stable(ir_act));

  assert_hiz_on_update_R8: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(outputs_hiz) |-> ($past(st) == ST_UPIR));

  assert_strobe_gate_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (cap_dr || shift_dr || upd_dr) |-> (sel_bsr && $onehot0({cap_dr, shift_dr, upd_dr})));

  assert_tdo_quiet_R10: assert property (@(posedge tck) disable iff (!rst_n)
    !tdo_oe |-> !tdo);

  assert_tdo_oe_state_R10: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (st == ST_SHIR || st == ST_SHDR));

endmodule

bind tap_ctrl tap_ctrl_chk u_chk (
  .tck         (tck),
  .rst_n       (rst_n),
  .tms         (tms),
  .st          (st),
  .ir_act      (ir_act),
  .tdo         (tdo),
  .tdo_oe      (tdo_oe),
  .sel_bsr     (sel_bsr),
  .cap_dr      (cap_dr),
  .shift_dr    (shift_dr),
  .upd_dr      (upd_dr),
  .outputs_hiz (outputs_hiz)
);

// File: tb/test_tap_ctrl.sv
module test_tap_ctrl;

  localparam logic [31:0] IDV  = 32'h1A5C_3069;
  localparam int          NB   = 36;
  localparam logic [35:0] TPAT = 36'h9_6C3A_5F0E;
  localparam logic [35:0] BPAT = 36'h5_A3C9_17E4;

  logic tck = 1'b0;
  logic rst_n, tms, tdi, bsr_so;
  logic tdo, tdo_oe, sel_bsr, extest_on, outputs_hiz, cap_dr, shift_dr, upd_dr;

  int checks = 0;
  int fails  = 0;
  int ncap = 0, nsh = 0, nupd = 0;
  bit done = 0;

  always #4 tck = ~tck;

  tap_ctrl #(.ID_VALUE(IDV)) i_tap_ctrl (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .sel_bsr(sel_bsr), .extest_on(extest_on),
    .outputs_hiz(outputs_hiz), .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr)
  );

  always @(negedge tck) begin
    if (cap_dr)   ncap++;
    if (shift_dr) nsh++;
    if (upd_dr)   nupd++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o, output logic oe);
    tms = m; tdi = d;
    @(negedge tck); #1 o = tdo; oe = tdo_oe;
    @(posedge tck); #1;
  endtask

  task automatic mv(input logic m);
    logic o, oe;
    step(m, 1'b0, o, oe);
  endtask

  function automatic logic [2:0] dec(input logic [2:0] c);
    return {c == 3'b000 || c == 3'b010 || c == 3'b100, c == 3'b000, c == 3'b010};
  endfunction

  task automatic ir_load(input logic [2:0] code, input logic [2:0] prev);
    logic [2:0] got;
    logic o, oe;
    mv(1); mv(1); mv(0); mv(0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], o, oe);
      got[i] = o;
    end
    chk("R3 capture pattern", got, 3'b001);
    mv(0);
    chk("R4 flags held in Pause-IR", {sel_bsr, extest_on, outputs_hiz}, dec(prev));
    mv(1); mv(1); mv(0);
    chk("R7 R8 decode after update", {sel_bsr, extest_on, outputs_hiz}, dec(code));
  endtask

  task automatic dr_scan(input logic [2:0] code);
    logic [35:0] got, exp;
    logic o, oe, oeall;
    int c0, s0, u0;
    c0 = ncap; s0 = nsh; u0 = nupd;
    oeall = 1'b1;
    mv(1); mv(0); mv(0);
    chk("R10 oe low until falling edge", tdo_oe, 1'b0);
    for (int i = 0; i < NB; i++) begin
      bsr_so = BPAT[i];
      step(i == NB - 1, TPAT[i], o, oe);
      got[i] = o;
      oeall &= oe;
      if (dec(code)[2])   exp[i] = BPAT[i];
      else if (code == 3'b001) exp[i] = (i < 32) ? IDV[i] : TPAT[i-32];
      else                exp[i] = (i == 0) ? 1'b0 : TPAT[i-1];
    end
    chk("R10 oe high in Shift-DR", oeall, 1'b1);
    if (dec(code)[2])        chk("R7 bsr path", got, exp);
    else if (code == 3'b001) chk("R5 idcode path", got, exp);
    else                     chk("R6 bypass path", got, exp);
    mv(1); mv(0);
    chk("R10 quiet in RTI", {tdo_oe, tdo}, 2'b00);
    if (dec(code)[2]) chk("R9 strobe counts", {ncap - c0, nsh - s0, nupd - u0}, {32'd1, NB, 32'd1});
    else              chk("R9 no strobes", {ncap - c0, nsh - s0, nupd - u0}, 96'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] prev;
    rst_n = 1'b0; tms = 1'b1; tdi = 1'b0; bsr_so = 1'b0;
    #20 @(posedge tck); #1 rst_n = 1'b1;
    chk("R10 reset tdo", {tdo_oe, tdo}, 2'b00);
    chk("R2 reset decode", {sel_bsr, extest_on, outputs_hiz}, 3'b000);
    mv(0);
    dr_scan(3'b001);

    prev = 3'b001;
    for (int c = 0; c < 8; c++) begin
      ir_load(c[2:0], prev);
      dr_scan(c[2:0]);
      prev = c[2:0];
    end

    ir_load(3'b010, prev);
    chk("R8 hiz active", outputs_hiz, 1'b1);
    ir_load(3'b100, 3'b010);
    chk("R8 hiz released", outputs_hiz, 1'b0);

    ir_load(3'b010, 3'b100);
    mv(1); mv(0); mv(0);
    mv(1); mv(1); mv(1); mv(1);
    chk("R1 four ones keep instruction", outputs_hiz, 1'b1);
    mv(1); mv(0);
    chk("R1 R2 fifth one resets to IDCODE", {sel_bsr, outputs_hiz}, 2'b00);
    dr_scan(3'b001);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule